// File: doc/BRIEF.md
# Four-Core Snooping Write-Through Coherence Cluster

This block contains four private direct-mapped caches and the shared main memory behind them. Each cache writes every store through to memory. The caches reach memory over one serialized bus, and every controller watches that bus. When one core's store completes on the bus, each other cache that holds the same address reacts in one of two ways, chosen at run time by a mode pin:

- In invalidate mode it drops its copy.
- In update mode it overwrites its copy with the new value and keeps the line valid.

Main memory is a model with a fixed latency and is built into the block.

Each core has one load/store port with a valid/ready request channel and a valid/ready response channel.

- **Request channel.** A core may present a request at any time. The request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while that core's cache is idle.
- **Response channel.** A response is offered with `rsp_valid`. It is held, with its data stable, until the core raises `rsp_ready`.
- **Outstanding requests.** Each core has at most one request in flight.

The bus is granted round-robin. Only one transaction is in flight at a time, so all stores fall into a single global order, and every load returns the most recent store in that order.

Top module: `snoop_wt_cluster`

## Requirements
- R1: After reset, every `req_ready` is high, every `rsp_valid` is low, and every memory word reads zero.
- R2: A load that misses goes to the bus and fills its line. With the bus idle, its response appears MEM_LAT+2 cycles after acceptance and carries the current memory value.
- R3: A load that hits in the local cache responds one cycle after acceptance with the cached word.
- R4: A store is written to memory and also allocates or overwrites the storing core's own line. Its response carries the stored word and appears MEM_LAT+2 cycles after acceptance when the bus is idle.
- R5: With `upd_mode`=0, a completed store invalidates every other cache's copy of that address. The next load there misses and returns the new value.
- R6: With `upd_mode`=1, a completed store overwrites every other cache's copy of that address and leaves it valid. The next load there hits and returns the new value.
- R7: The line index is `addr[IDXW-1:0]` and the tag is the remaining upper bits. An access to a different tag at the same index misses and replaces the line.
- R8: The bus serves one transaction at a time. After a grant to core k, the search for the next grant starts at core k+1 and wraps. After reset, core 0 has first priority.
- R9: When all four cores issue requests together, every load returns the value of the most recent store to that address in bus order.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response and its data hold stable and `req_ready` stays low. After the response is taken, `req_ready` returns high.
- R11: When a snoop from a completing store and a local load lookup hit the same line in the same cycle, the snoop takes effect first. The load never sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_mode | input | 1 | 0: snoop invalidates, 1: snoop updates |
| req_valid | input | NC | Per-core request valid |
| req_ready | output | NC | Per-core request ready (cache idle) |
| req_we | input | NC | Per-core request is a store |
| req_addr | input | NC*AW | Per-core word address, core i at bits [i*AW +: AW] |
| req_wdata | input | NC*DW | Per-core store data |
| rsp_valid | output | NC | Per-core response valid |
| rsp_ready | input | NC | Per-core response ready |
| rsp_rdata | output | NC*DW | Per-core load data, or the stored word for a store |

## Verification
The main function is exercised with four input patterns:

- **Solo accesses.** One core at a time issues requests. These runs distinguish a hit from a miss by the response latency alone, so a line that should have been invalidated but still hits is caught even though its data is correct.
- **Mode comparison.** The same store-then-remote-load pattern runs in both modes. The remote load must miss after an invalidate and hit after an update, which separates the two snoop actions.
- **Same-cycle race.** A load is timed to reach its lookup in the very cycle a snoop lands on that line. This isolates the snoop-first ordering.
- **All cores at once.** All four cores issue at the same time, first to distinct addresses and then to a single address. The per-core latencies expose the round-robin grant order, and the final value all caches agree on exposes the global store order.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // per-core cache controller phase
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_BUS  = 2'd1,
    CS_RESP = 2'd2
  } cstate_e;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          req,
  input  logic                  en,
  output logic [N-1:0]          gnt,
  output logic [$clog2(N)-1:0]  gnt_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;
  logic          found;

  // search starts one past the last winner
  always_comb begin
    found   = 1'b0;
    gnt_idx = '0;
    for (int off = 1; off <= N; off++) begin
      if (!found && req[(int'(ptr_q) + off) % N]) begin
        found   = 1'b1;
        gnt_idx = IW'((int'(ptr_q) + off) % N);
      end
    end
    gnt = '0;
    if (en && found) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ptr_q <= IW'(N - 1);
    else if (en && found)   ptr_q <= gnt_idx;
  end
endmodule

// File: rtl/coh_mem_model.sv
module coh_mem_model #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          we_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;

  assign done  = busy && (cnt_q == '0);
  assign rdata = mem[a_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      we_q  <= 1'b0;
      a_q   <= '0;
      wd_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CW'(LAT - 1);
      we_q  <= we;
      a_q   <= addr;
      wd_q  <= wdata;
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy <= 1'b0;
        if (we_q) mem[a_q] <= wd_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/coh_l1_cache.sv
module coh_l1_cache
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int NLINE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  // core side
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  // bus master side
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  // snoop side
  input  logic          snp_valid,
  input  logic          snp_upd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data
);
  localparam int IDXW = $clog2(NLINE);
  localparam int TAGW = AW - IDXW;

  logic [NLINE-1:0] vld_q;
  logic [TAGW-1:0]  tag_q [NLINE];
  logic [DW-1:0]    dat_q [NLINE];

  cstate_e       st_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rsp_q;

  logic [IDXW-1:0] sidx, lidx, fidx;
  logic [TAGW-1:0] stag, ltag, ftag;
  logic            snp_hit, base_hit, same_line, eff_hit;
  logic [DW-1:0]   eff_data, fill_data;

  assign sidx = snp_addr[IDXW-1:0];
  assign stag = snp_addr[AW-1:IDXW];
  assign lidx = req_addr[IDXW-1:0];
  assign ltag = req_addr[AW-1:IDXW];
  assign fidx = addr_q[IDXW-1:0];
  assign ftag = addr_q[AW-1:IDXW];

  assign snp_hit   = snp_valid && vld_q[sidx] && (tag_q[sidx] == stag);
  assign base_hit  = vld_q[lidx] && (tag_q[lidx] == ltag);
  // a snoop landing on the looked-up line this cycle is applied first
  assign same_line = snp_hit && (sidx == lidx) && (stag == ltag);
  assign eff_hit   = base_hit && !(same_line && !snp_upd);
  assign eff_data  = (same_line && snp_upd) ? snp_data : dat_q[lidx];
  assign fill_data = we_q ? wd_q : bus_rdata;

  assign req_ready = (st_q == CS_IDLE);
  assign rsp_valid = (st_q == CS_RESP);
  assign rsp_rdata = rsp_q;
  assign bus_req   = (st_q == CS_BUS);
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rsp_q  <= '0;
    end else begin
      unique case (st_q)
        CS_IDLE: if (req_valid) begin
          we_q   <= req_we;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          if (!req_we && eff_hit) begin
            rsp_q <= eff_data;
            st_q  <= CS_RESP;
          end else begin
            st_q  <= CS_BUS;
          end
        end
        CS_BUS: if (bus_done) begin
          rsp_q <= fill_data;
          st_q  <= CS_RESP;
        end
        CS_RESP: if (rsp_ready) st_q <= CS_IDLE;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  // line array: snoop first, own fill after (never the same cycle in practice)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NLINE; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (snp_hit) begin
        if (snp_upd) dat_q[sidx] <= snp_data;
        else         vld_q[sidx] <= 1'b0;
      end
      if (st_q == CS_BUS && bus_done) begin
        vld_q[fidx] <= 1'b1;
        tag_q[fidx] <= ftag;
        dat_q[fidx] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/snoop_wt_cluster.sv
module snoop_wt_cluster #(
  parameter int NC      = 4,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int NLINE   = 8,
  parameter int MEM_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_mode,
  input  logic [NC-1:0]    req_valid,
  output logic [NC-1:0]    req_ready,
  input  logic [NC-1:0]    req_we,
  input  logic [NC*AW-1:0] req_addr,
  input  logic [NC*DW-1:0] req_wdata,
  output logic [NC-1:0]    rsp_valid,
  input  logic [NC-1:0]    rsp_ready,
  output logic [NC*DW-1:0] rsp_rdata
);
  localparam int IW = $clog2(NC);

  logic [NC-1:0] bus_req;
  logic          c_we    [NC];
  logic [AW-1:0] c_addr  [NC];
  logic [DW-1:0] c_wdata [NC];

  logic [NC-1:0] gnt;
  logic [IW-1:0] gnt_idx;
  logic          start;
  logic          mem_busy, mem_done;
  logic [DW-1:0] mem_rdata;

  logic [IW-1:0] owner_q;
  logic          op_we_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;

  assign start = !mem_busy && (|bus_req);

  coh_rr_arb #(.N(NC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bus_req),
    .en      (start),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  coh_mem_model #(.AW(AW), .DW(DW), .LAT(MEM_LAT)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .we    (c_we[gnt_idx]),
    .addr  (c_addr[gnt_idx]),
    .wdata (c_wdata[gnt_idx]),
    .busy  (mem_busy),
    .done  (mem_done),
    .rdata (mem_rdata)
  );

  // transaction record used to drive the snoop broadcast
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= '0;
      op_we_q   <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (start) begin
      owner_q   <= gnt_idx;
      op_we_q   <= c_we[gnt_idx];
      op_addr_q <= c_addr[gnt_idx];
      op_data_q <= c_wdata[gnt_idx];
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_core
    coh_l1_cache #(.AW(AW), .DW(DW), .NLINE(NLINE)) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[i]),
      .req_ready (req_ready[i]),
      .req_we    (req_we[i]),
      .req_addr  (req_addr[i*AW +: AW]),
      .req_wdata (req_wdata[i*DW +: DW]),
      .rsp_valid (rsp_valid[i]),
      .rsp_ready (rsp_ready[i]),
      .rsp_rdata (rsp_rdata[i*DW +: DW]),
      .bus_req   (bus_req[i]),
      .bus_we    (c_we[i]),
      .bus_addr  (c_addr[i]),
      .bus_wdata (c_wdata[i]),
      .bus_done  (mem_done && (owner_q == IW'(i))),
      .bus_rdata (mem_rdata),
      .snp_valid (mem_done && op_we_q && (owner_q != IW'(i))),
      .snp_upd   (upd_mode),
      .snp_addr  (op_addr_q),
      .snp_data  (op_data_q)
    );
  end
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int NC = 4,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NC-1:0]    gnt,
  input logic [NC-1:0]    req_ready,
  input logic [NC-1:0]    rsp_valid,
  input logic [NC-1:0]    rsp_ready,
  input logic [NC*DW-1:0] rsp_rdata,
  input logic             mem_done,
  input logic [$clog2(NC)-1:0] owner_q
);
  localparam int IW = $clog2(NC);

  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  for (genvar i = 0; i < NC; i++) begin : g_c
    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && !rsp_ready[i]) |=> (rsp_valid[i] && $stable(rsp_rdata[i*DW +: DW])));
    // R10
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && rsp_ready[i]) |=> req_ready[i]);
    // R4
    done_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_done && owner_q == IW'(i)) |=> rsp_valid[i]);
  end
endmodule

bind snoop_wt_cluster coh_chk #(.NC(NC), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt       (gnt),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .mem_done  (mem_done),
  .owner_q   (owner_q)
);

// File: tb/snoop_wt_cluster_tb_top.sv
`timescale 1ns/1ps
module snoop_wt_cluster_tb_top;
  localparam int NC  = 4;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LAT = 2;
  localparam int HIT = 1;
  localparam int MIS = LAT + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             upd_mode = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_ready;
  logic [NC-1:0]    req_we = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]    rsp_valid;
  logic [NC-1:0]    rsp_ready = '1;
  logic [NC*DW-1:0] rsp_rdata;

  always #2.5 clk = ~clk;

  snoop_wt_cluster #(.NC(NC), .AW(AW), .DW(DW), .NLINE(8), .MEM_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_mode(upd_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit fin = 1'b0;
  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] exp_d [NC][$];
  int            exp_l [NC][$];
  string         exp_r [NC][$];
  int            st_cyc [NC];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // driver: compute expectation from bus order and push it
  task automatic start_op(int c, bit we, logic [AW-1:0] a, logic [DW-1:0] d, int lat, string rq);
    chk(req_ready[c] == 1'b1, rq, "req_ready before issue", DW'(req_ready[c]), 1);
    req_valid[c] = 1'b1;
    req_we[c] = we;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = d;
    if (we) begin
      ref_mem[a] = d;
      exp_d[c].push_back(d);
    end else begin
      exp_d[c].push_back(ref_mem[a]);
    end
    exp_l[c].push_back(lat);
    exp_r[c].push_back(rq);
    st_cyc[c] = cyc;
  endtask

  task automatic op_at(int c, bit we, logic [AW-1:0] a, logic [DW-1:0] d, int lat, string rq, int dly);
    @(negedge clk);
    repeat (dly) @(negedge clk);
    start_op(c, we, a, d, lat, rq);
    @(posedge clk);
    @(negedge clk);
    req_valid[c] = 1'b0;
    while (exp_d[c].size() != 0) @(negedge clk);
  endtask

  // monitor: pop and compare on every response handshake
  always @(negedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (rsp_valid[c] && rsp_ready[c]) begin
        if (exp_d[c].size() == 0) begin
          chk(1'b0, "R9", "unexpected response", rsp_rdata[c*DW +: DW], '0);
        end else begin
          logic [DW-1:0] ed;
          int el;
          string er;
          ed = exp_d[c].pop_front();
          el = exp_l[c].pop_front();
          er = exp_r[c].pop_front();
          chk(rsp_rdata[c*DW +: DW] == ed, er, $sformatf("core%0d data", c), rsp_rdata[c*DW +: DW], ed);
          if (el != 0)
            chk((cyc - st_cyc[c]) == el, er, $sformatf("core%0d latency", c), DW'(cyc - st_cyc[c]), DW'(el));
        end
      end
    end
  end

  localparam logic [AW-1:0] A = 8'h10;  // index 0, tag 2
  localparam logic [AW-1:0] C = 8'h18;  // index 0, tag 3
  localparam logic [AW-1:0] B = 8'h25;  // index 5

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(req_ready == '1, "R1", "req_ready after reset", DW'(req_ready), DW'(4'hF));
    chk(rsp_valid == '0, "R1", "rsp_valid after reset", DW'(rsp_valid), 0);
    op_at(3, 0, 8'h3C, 0, MIS, "R1", 0);

    // R2 miss then R3 hit
    op_at(0, 0, A, 0, MIS, "R2", 0);
    op_at(0, 0, A, 0, HIT, "R3", 0);
    op_at(1, 0, A, 0, MIS, "R2", 0);
    op_at(1, 0, A, 0, HIT, "R3", 0);

    // R4 / R5 invalidate mode
    upd_mode = 1'b0;
    op_at(0, 1, A, 32'h1111, MIS, "R4", 0);
    op_at(0, 0, A, 0, HIT, "R4", 0);
    op_at(1, 0, A, 0, MIS, "R5", 0);
    op_at(1, 0, A, 0, HIT, "R5", 0);

    // R6 update mode
    upd_mode = 1'b1;
    op_at(2, 0, A, 0, MIS, "R6", 0);
    op_at(2, 1, A, 32'h2222, MIS, "R6", 0);
    op_at(0, 0, A, 0, HIT, "R6", 0);
    op_at(1, 0, A, 0, HIT, "R6", 0);

    // R7 index conflict
    op_at(0, 0, C, 0, MIS, "R7", 0);
    op_at(0, 0, A, 0, MIS, "R7", 0);
    op_at(0, 0, C, 0, MIS, "R7", 0);
    op_at(0, 0, A, 0, MIS, "R7", 0);

    // R11 snoop lands in the same cycle as a lookup, update mode: hit with new data
    fork
      op_at(0, 1, A, 32'h3333, MIS, "R11", 0);
      op_at(1, 0, A, 0, HIT, "R11", LAT + 1);
    join
    // R11 invalidate mode: same timing must miss and return new data
    upd_mode = 1'b0;
    fork
      op_at(0, 1, A, 32'h4444, MIS, "R11", 0);
      op_at(1, 0, A, 0, MIS, "R11", LAT + 1);
    join

    // R9 concurrent stores to distinct addresses, then cross loads
    upd_mode = 1'b1;
    fork
      op_at(0, 1, 8'h40, 32'hA0, 0, "R9", 0);
      op_at(1, 1, 8'h41, 32'hA1, 0, "R9", 0);
      op_at(2, 1, 8'h42, 32'hA2, 0, "R9", 0);
      op_at(3, 1, 8'h43, 32'hA3, 0, "R9", 0);
    join
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < NC; k++)
        op_at(c, 0, AW'(8'h40 + k), 0, 0, "R9", 0);

    // R8 round robin: last bus user is core 3, so order is 0,1,2,3
    for (int c = 0; c < NC; c++) op_at(c, 0, B, 0, MIS, "R8", 0);
    fork
      op_at(0, 1, B, 32'hB000, MIS, "R8", 0);
      op_at(1, 1, B, 32'hB001, MIS + (LAT + 1), "R8", 0);
      op_at(2, 1, B, 32'hB002, MIS + 2 * (LAT + 1), "R8", 0);
      op_at(3, 1, B, 32'hB003, MIS + 3 * (LAT + 1), "R8", 0);
    join
    ref_mem[B] = 32'hB003;  // R9: last in bus order wins
    for (int c = 0; c < NC; c++) op_at(c, 0, B, 0, HIT, "R9", 0);

    // R10 response back-pressure
    @(negedge clk);
    rsp_ready[2] = 1'b0;
    start_op(2, 0, B, 0, 0, "R10");
    @(posedge clk);
    @(negedge clk);
    req_valid[2] = 1'b0;
    begin
      logic [DW-1:0] held;
      held = rsp_rdata[2*DW +: DW];
      repeat (3) begin
        @(negedge clk);
        chk(rsp_valid[2] == 1'b1, "R10", "rsp_valid held", DW'(rsp_valid[2]), 1);
        chk(req_ready[2] == 1'b0, "R10", "req_ready low while pending", DW'(req_ready[2]), 0);
        chk(rsp_rdata[2*DW +: DW] == held, "R10", "data stable", rsp_rdata[2*DW +: DW], held);
      end
    end
    rsp_ready[2] = 1'b1;
    while (exp_d[2].size() != 0) @(negedge clk);
    @(negedge clk);
    chk(req_ready[2] == 1'b1, "R10", "req_ready after take", DW'(req_ready[2]), 1);

    if (!fin) begin
      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule